// File: doc/BRIEF.md
# FIFO Threshold Service Interrupt

This block is a 16-byte transmit queue on the path from a host to a peripheral. The host pushes bytes through a write port. The peripheral drains them through a valid/ready read port. Whenever the fill level drops to a programmable watermark or below, the block raises a service request so the host can refill the queue. The comparison is "less than or equal to". This means that, once a request is seen, the host can always push at least depth minus watermark bytes in one burst without losing any. From an empty queue it can push a full 16-byte burst.

The request is gated by a service mask bit. When the request fires, the hardware sets the mask. Software clears the mask to re-arm the request, so a level that stays low produces one event per re-arm. A write to a full queue is discarded and latches a sticky overflow flag. A read from an empty queue has no effect.

Top module: `fifo_svc_irq`

## Requirements
- R1: Bytes leave in the order they were written, up to 16 held. `rd_data` shows the oldest byte while `rd_valid` is 1. A byte is removed on a clock edge where `rd_valid` and `rd_ready` are both 1.
- R2: `irq` is 1 exactly when the mask bit is 0 and the fill count is less than or equal to the watermark. It follows the registered state in the cycle after the edge that changed that state.
- R3: A write with `thr_we`=1 loads `thr_in` into the watermark at the next edge. With watermark 12, the request is live at fill levels 12 and below and silent at 13 and above.
- R4: On the edge after a cycle with `irq`=1, the mask bit becomes 1. A software write (`mask_we`=1) in that same cycle takes priority and loads `mask_in`. A level that stays low gives one single-cycle `irq` pulse per re-arm.
- R5: A write while the fill count is 16 is dropped, even if a read happens in the same cycle. Such a write sets `ovf`, which stays 1 until reset.
- R6: `fill_cnt` (0 to 16) changes at the edge: +1 for an accepted write, -1 for a read, and unchanged when both happen in the same cycle.
- R7: After a request at watermark T, writing 16-T bytes leaves `ovf` at 0. From an empty queue, 16 bytes fit.
- R8: After reset the queue is empty, the mask bit is 1, `irq` and `ovf` are 0, and the watermark is 8.
- R9: Asserting `rd_ready` while the queue is empty leaves `fill_cnt` at 0 and `rd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| thr_we | input | 1 | Watermark register write |
| thr_in | input | 4 | New watermark value |
| mask_we | input | 1 | Service mask write |
| mask_in | input | 1 | New mask value (0 arms the request) |
| rd_valid | output | 1 | Queue holds a byte |
| rd_data | output | 8 | Oldest byte |
| rd_ready | input | 1 | Peripheral takes the oldest byte |
| irq | output | 1 | Service request |
| svc_mask | output | 1 | Current mask bit |
| fill_cnt | output | 5 | Bytes held |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Every result settles one edge after the stimulus that causes it. `fill_cnt`, `ovf`, the watermark and the mask bit are registered there. `rd_valid`, `rd_data` and `irq` are decoded from those registers without further delay, so they are due in the same cycle. The bench drives inputs on the falling edge and steps a behavioural queue model across the next rising edge. It then compares all outputs at the following falling edge, so every value is checked exactly one edge after its cause. The mask set that follows an `irq` pulse is therefore seen one comparison later as `irq` back at 0.

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int THR_RST = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         thr_we,
  input  logic [$clog2(DEPTH)-1:0]     thr_in,
  input  logic                         mask_we,
  input  logic                         mask_in,
  output logic                         rd_valid,
  output logic [DW-1:0]                rd_data,
  input  logic                         rd_ready,
  output logic                         irq,
  output logic                         svc_mask,
  output logic [$clog2(DEPTH+1)-1:0]   fill_cnt,
  output logic                         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, thr_q;
  logic [CW-1:0] cnt;
  logic          mask_q, ovf_q;

  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);
  wire push  = wr_en & ~full;
  wire pop   = rd_ready & ~empty;

  assign rd_valid = ~empty;
  assign rd_data  = mem[rptr];
  assign irq      = ~mask_q & (cnt <= CW'(thr_q));
  assign svc_mask = mask_q;
  assign fill_cnt = cnt;
  assign ovf      = ovf_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      thr_q  <= AW'(THR_RST);
      mask_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (thr_we) thr_q <= thr_in;
      if (mask_we)  mask_q <= mask_in;
      else if (irq) mask_q <= 1'b1;
      if (wr_en && full) ovf_q <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R6
  AST_FILL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !(rd_ready && !empty)) |=> cnt == $past(cnt) + 1'b1); // R6
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && rd_ready && !empty) |=> $stable(cnt)); // R6
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mask_we) |=> svc_mask); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_ready) |=> (cnt == CW'(DEPTH)) && ovf_q); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_ready && !wr_en) |=> (cnt == '0) && !rd_valid); // R9
endmodule

// File: tb/fifo_svc_irq_tb.sv
module fifo_svc_irq_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, thr_we = 0, mask_we = 0, mask_in = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] thr_in = 0;
  logic rd_valid, irq, svc_mask, ovf;
  logic [7:0] rd_data;
  logic [4:0] fill_cnt;

  int n_cmp = 0, n_bad = 0, pulses = 0;
  logic [7:0] q[$];
  int m_thr = 8;
  bit m_mask = 1, m_ovf = 0;

  always #2 clk = ~clk;

  fifo_svc_irq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .thr_we(thr_we), .thr_in(thr_in), .mask_we(mask_we), .mask_in(mask_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .irq(irq),
    .svc_mask(svc_mask), .fill_cnt(fill_cnt), .ovf(ovf));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_irq = !m_mask && (q.size() <= m_thr);
    chk(fill_cnt == q.size(), "R6 fill", fill_cnt, q.size());
    chk(rd_valid == (q.size() != 0), "R9 valid", rd_valid, q.size() != 0);
    if (q.size() != 0) chk(rd_data == q[0], "R1 data", rd_data, q[0]);
    chk(irq == e_irq, "R2 irq", irq, e_irq);
    chk(svc_mask == m_mask, "R4 mask", svc_mask, m_mask);
    chk(ovf == m_ovf, "R5 ovf", ovf, m_ovf);
    if (irq) pulses++;
  endtask

  task automatic step(bit w, logic [7:0] d, bit r, bit tw = 0, int tv = 0, bit mw = 0, bit mv = 0);
    bit e_irq, full, pop, push;
    compare();
    wr_en = w; wr_data = d; rd_ready = r; thr_we = tw; thr_in = tv[3:0];
    mask_we = mw; mask_in = mv;
    e_irq = !m_mask && (q.size() <= m_thr);
    full = (q.size() == 16);
    pop = r && q.size() != 0;
    push = w && !full;
    @(posedge clk);
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    if (w && full) m_ovf = 1;
    if (mw) m_mask = mv; else if (e_irq) m_mask = 1;
    if (tw) m_thr = tv;
    @(negedge clk);
    wr_en = 0; rd_ready = 0; thr_we = 0; mask_we = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    chk(fill_cnt == 0 && !rd_valid, "R8 empty", fill_cnt, 0);
    chk(svc_mask == 1 && !irq && !ovf, "R8 mask/irq/ovf", {svc_mask, irq, ovf}, 3'b100);
    // R9 read while empty
    step(0, 0, 1); step(0, 0, 1);
    chk(fill_cnt == 0 && !rd_valid, "R9 empty read", fill_cnt, 0);
    // R3 watermark 12, R4 arm: one pulse at level 0
    step(0, 0, 0, 1, 12);
    step(0, 0, 0, 0, 0, 1, 0);
    p0 = pulses;
    repeat (4) step(0, 0, 0);
    chk(pulses - p0 == 1, "R4 single pulse", pulses - p0, 1);
    // R7 full burst from empty
    for (int i = 0; i < 16; i++) step(1, 8'(i + 8'h40), 0);
    compare();
    chk(fill_cnt == 16 && !ovf, "R7 empty burst 16", fill_cnt, 16);
    // R3: arm at 16, drain to 13: silent; at 12: pulse
    step(0, 0, 0, 0, 0, 1, 0);
    p0 = pulses;
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    compare();
    chk(pulses - p0 == 0 && fill_cnt == 13, "R3 silent at 13", pulses - p0, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    chk(pulses - p0 == 1, "R3 fires at 12", pulses - p0, 1);
    // R7 burst of 16-12 after request
    for (int i = 0; i < 4; i++) step(1, 8'(i + 8'h80), 0);
    compare();
    chk(fill_cnt == 16 && !ovf, "R7 burst 16-T", fill_cnt, 16);
    // R5 write to full with simultaneous read is dropped
    step(1, 8'hEE, 1);
    compare();
    chk(fill_cnt == 15 && ovf, "R5 drop on full", fill_cnt, 15);
    // R6 simultaneous read and write
    step(1, 8'h11, 1);
    compare();
    chk(fill_cnt == 15, "R6 rd+wr hold", fill_cnt, 15);
    // R4 software priority over hardware set
    step(0, 0, 0, 1, 15);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    compare();
    chk(irq == 1, "R4 sw write wins", irq, 1);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 2) != 0, 8'($urandom), $urandom_range(0, 2) != 0,
           $urandom_range(0, 40) == 0, $urandom_range(0, 15),
           $urandom_range(0, 20) == 0, $urandom_range(0, 3) == 0);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule